// File: doc/BRIEF.md
# Store-Load Address Overlap Detector

This block watches the memory operations placed into one dispatch group and flags a load that may read bytes written by an earlier store in the same group. Each address is described by two operand tags. An operand is either a register identifier or a signed constant offset. No address is ever computed. The block only compares operand identities and, where a shared base allows it, constant offsets.

A store presented with `st_en` overwrites the single recorded store, which holds its two operands and its access size. A load presented with `ld_en` is compared at once against that record, and the single `conflict` bit answers in the same cycle. A scheduler raises `grp_end` when it closes a group, and that empties the record.

Access sizes arrive as a two-bit code. A record whose size decodes to zero bytes counts as empty.

Top module: `sld_detector`

## Requirements
- R1: A load conflicts when its first operand equals the recorded first operand and its second operand equals the recorded second operand. Two operands are equal when both the const flag and the 16-bit value match.
- R2: A load conflicts when its operands equal the recorded pair crossed over, that is load first equals store second and load second equals store first.
- R3: When both first operands are constants, the second operands are equal, and the store offset is the smaller of the two signed offsets, the load conflicts exactly when store offset plus store bytes is greater than the load offset.
- R4: Under the same shared-base condition, when the store offset is not the smaller one, the load conflicts exactly when load offset plus load bytes is greater than the store offset.
- R5: The size code maps as follows: 1 is a 4-byte word, 2 is an 8-byte double, and 0 or 3 is zero bytes.
- R6: If the recorded store size is zero bytes, `conflict` stays 0 for every load.
- R7: Each accepted store replaces the whole previous record, including its operands and its size.
- R8: `grp_end` empties the record from the next cycle on. It wins over an `st_en` in the same cycle.
- R9: Synchronous reset `rst` empties the record.
- R10: `conflict` is 0 whenever `ld_en` is 0. It follows the current load inputs in the same cycle, with no register in the path.
- R11: Offsets are signed 16-bit values. The overlap sums are formed at 17 bits, so offsets near +32767 and near -32768 compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_end | input | 1 | Close the group and empty the record |
| st_en | input | 1 | Record the store on the st_* inputs |
| st_a_const | input | 1 | Store first operand is a constant |
| st_a_val | input | 16 | Store first operand: offset or register id |
| st_b_const | input | 1 | Store second operand is a constant |
| st_b_val | input | 16 | Store second operand value |
| st_size | input | 2 | Store size code |
| ld_en | input | 1 | A load is presented |
| ld_a_const | input | 1 | Load first operand is a constant |
| ld_a_val | input | 16 | Load first operand value |
| ld_b_const | input | 1 | Load second operand is a constant |
| ld_b_val | input | 16 | Load second operand value |
| ld_size | input | 2 | Load size code |
| conflict | output | 1 | Load may hit the recorded store |

## Verification
The bench builds the block with its default 16-bit operands and 2-bit size codes. It sweeps every store offset and load offset from -12 to +12 against all four store size codes and all four load size codes. This covers both overlap branches, the empty-record case, the equal-offset exact match and the reserved code. Separate passes place offsets against both ends of the signed range to test the 17-bit sums. Further passes cover register-only pairs, crossed pairs, replacement of the record, and clearing by `grp_end` and reset.

// File: rtl/sld_pkg.sv
package sld_pkg;
    localparam int OPND_W  = 16;
    localparam int BYTES_W = 4;
    localparam int SUM_W   = OPND_W + 1;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_DBL  = 2'd2,
        SZ_RSVD = 2'd3
    } size_code_e;

    typedef struct packed {
        logic              is_const;
        logic [OPND_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic [BYTES_W-1:0] bytes;
        opnd_t              a;
        opnd_t              b;
    } st_rec_t;

    function automatic logic [BYTES_W-1:0] sz_bytes(input logic [1:0] code);
        case (code)
            SZ_WORD: sz_bytes = BYTES_W'(4);
            SZ_DBL:  sz_bytes = BYTES_W'(8);
            default: sz_bytes = '0;
        endcase
    endfunction

    function automatic logic opnd_eq(input opnd_t x, input opnd_t y);
        opnd_eq = (x.is_const == y.is_const) && (x.val == y.val);
    endfunction
endpackage

// File: rtl/sld_store_rec.sv
module sld_store_rec
    import sld_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    wr,
    input  st_rec_t wr_rec,
    output st_rec_t rec,
    output logic    rec_live
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rec <= '0;
        end else if (wr) begin
            rec <= wr_rec;
        end
    end

    assign rec_live = (rec.bytes != '0);
endmodule

// File: rtl/sld_pair_match.sv
module sld_pair_match
    import sld_pkg::*;
(
    input  opnd_t st_a,
    input  opnd_t st_b,
    input  opnd_t ld_a,
    input  opnd_t ld_b,
    output logic  same_order,
    output logic  crossed
);
    assign same_order = opnd_eq(ld_a, st_a) && opnd_eq(ld_b, st_b);
    assign crossed    = opnd_eq(ld_a, st_b) && opnd_eq(ld_b, st_a);
endmodule

// File: rtl/sld_offset_overlap.sv
module sld_offset_overlap
    import sld_pkg::*;
(
    input  opnd_t              st_a,
    input  opnd_t              st_b,
    input  opnd_t              ld_a,
    input  opnd_t              ld_b,
    input  logic [BYTES_W-1:0] st_bytes,
    input  logic [BYTES_W-1:0] ld_bytes,
    output logic               hit
);
    localparam int PAD_W = SUM_W - BYTES_W;

    logic signed [SUM_W-1:0] st_off, ld_off, st_end, ld_end;
    logic                    shared_base;

    always_comb begin
        st_off = $signed({st_a.val[OPND_W-1], st_a.val});
        ld_off = $signed({ld_a.val[OPND_W-1], ld_a.val});
        st_end = st_off + $signed({{PAD_W{1'b0}}, st_bytes});
        ld_end = ld_off + $signed({{PAD_W{1'b0}}, ld_bytes});
        shared_base = st_a.is_const && ld_a.is_const && opnd_eq(st_b, ld_b);
        if (!shared_base) begin
            hit = 1'b0;
        end else if (st_off < ld_off) begin
            hit = (st_end > ld_off);
        end else begin
            hit = (ld_end > st_off);
        end
    end
endmodule

// File: rtl/sld_detector.sv
module sld_detector
    import sld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              grp_end,
    input  logic              st_en,
    input  logic              st_a_const,
    input  logic [OPND_W-1:0] st_a_val,
    input  logic              st_b_const,
    input  logic [OPND_W-1:0] st_b_val,
    input  logic [1:0]        st_size,
    input  logic              ld_en,
    input  logic              ld_a_const,
    input  logic [OPND_W-1:0] ld_a_val,
    input  logic              ld_b_const,
    input  logic [OPND_W-1:0] ld_b_val,
    input  logic [1:0]        ld_size,
    output logic              conflict
);
    st_rec_t new_rec, rec;
    opnd_t   ld_a, ld_b;
    logic    rec_live, same_order, crossed, ovl_hit;

    always_comb begin
        new_rec.bytes = sz_bytes(st_size);
        new_rec.a     = '{is_const: st_a_const, val: st_a_val};
        new_rec.b     = '{is_const: st_b_const, val: st_b_val};
        ld_a          = '{is_const: ld_a_const, val: ld_a_val};
        ld_b          = '{is_const: ld_b_const, val: ld_b_val};
    end

    sld_store_rec u_rec (
        .clk(clk), .rst(rst), .clr(grp_end), .wr(st_en),
        .wr_rec(new_rec), .rec(rec), .rec_live(rec_live)
    );

    sld_pair_match u_match (
        .st_a(rec.a), .st_b(rec.b), .ld_a(ld_a), .ld_b(ld_b),
        .same_order(same_order), .crossed(crossed)
    );

    sld_offset_overlap u_ovl (
        .st_a(rec.a), .st_b(rec.b), .ld_a(ld_a), .ld_b(ld_b),
        .st_bytes(rec.bytes), .ld_bytes(sz_bytes(ld_size)), .hit(ovl_hit)
    );

    assign conflict = ld_en && rec_live && (same_order || crossed || ovl_hit);
endmodule

// File: rtl/sld_detector_chk.sv
module sld_detector_chk
    import sld_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              grp_end,
    input logic              st_en,
    input logic              st_a_const,
    input logic [OPND_W-1:0] st_a_val,
    input logic              st_b_const,
    input logic [OPND_W-1:0] st_b_val,
    input logic [1:0]        st_size,
    input logic              ld_en,
    input logic              ld_a_const,
    input logic [OPND_W-1:0] ld_a_val,
    input logic              ld_b_const,
    input logic [OPND_W-1:0] ld_b_val,
    input logic              conflict
);
    logic st_took;
    assign st_took = st_en && !grp_end && (st_size == 2'd1 || st_size == 2'd2);

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !ld_en |-> !conflict); // R10

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        grp_end |=> !conflict); // R8

    AST_RESET_EMPTIES: assert property (@(posedge clk)
        rst |=> !conflict); // R9

    AST_SAME_ORDER: assert property (@(posedge clk) disable iff (rst)
        (ld_en && $past(st_took)
         && {ld_a_const, ld_a_val} == $past({st_a_const, st_a_val})
         && {ld_b_const, ld_b_val} == $past({st_b_const, st_b_val}))
        |-> conflict); // R1

    AST_CROSSED: assert property (@(posedge clk) disable iff (rst)
        (ld_en && $past(st_took)
         && {ld_a_const, ld_a_val} == $past({st_b_const, st_b_val})
         && {ld_b_const, ld_b_val} == $past({st_a_const, st_a_val}))
        |-> conflict); // R2

    AST_EMPTY_SIZE: assert property (@(posedge clk) disable iff (rst)
        (st_en && !grp_end && (st_size == 2'd0 || st_size == 2'd3)) |=> !conflict); // R6
endmodule

bind sld_detector sld_detector_chk u_chk (
    .clk(clk), .rst(rst), .grp_end(grp_end), .st_en(st_en),
    .st_a_const(st_a_const), .st_a_val(st_a_val),
    .st_b_const(st_b_const), .st_b_val(st_b_val), .st_size(st_size),
    .ld_en(ld_en), .ld_a_const(ld_a_const), .ld_a_val(ld_a_val),
    .ld_b_const(ld_b_const), .ld_b_val(ld_b_val), .conflict(conflict)
);

// File: tb/sld_detector_tb.sv
module sld_detector_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        grp_end = 1'b0;
    logic        st_en = 1'b0, st_a_const = 1'b0, st_b_const = 1'b0;
    logic [15:0] st_a_val = '0, st_b_val = '0;
    logic [1:0]  st_size = '0;
    logic        ld_en = 1'b0, ld_a_const = 1'b0, ld_b_const = 1'b0;
    logic [15:0] ld_a_val = '0, ld_b_val = '0;
    logic [1:0]  ld_size = '0;
    logic        conflict;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    sld_detector u_dut (
        .clk(clk), .rst(rst), .grp_end(grp_end), .st_en(st_en),
        .st_a_const(st_a_const), .st_a_val(st_a_val),
        .st_b_const(st_b_const), .st_b_val(st_b_val), .st_size(st_size),
        .ld_en(ld_en), .ld_a_const(ld_a_const), .ld_a_val(ld_a_val),
        .ld_b_const(ld_b_const), .ld_b_val(ld_b_val), .ld_size(ld_size),
        .conflict(conflict)
    );

    function automatic int bytes_of(input int code);
        return (code == 1) ? 4 : (code == 2) ? 8 : 0;
    endfunction

    function automatic logic exp_ovl(input int so, input int sc, input int lo, input int lc);
        int sb = bytes_of(sc);
        int lb = bytes_of(lc);
        if (sb == 0) return 1'b0;
        if (so == lo) return 1'b1;
        if (so < lo) return (so + sb > lo);
        return (lo + lb > so);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s conflict=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic put_store(input logic ac, input int av, input logic bc, input int bv, input int code);
        st_en = 1'b1; st_a_const = ac; st_a_val = 16'(av);
        st_b_const = bc; st_b_val = 16'(bv); st_size = 2'(code);
        @(posedge clk); #1;
        st_en = 1'b0;
    endtask

    task automatic put_load(input logic ac, input int av, input logic bc, input int bv, input int code);
        ld_en = 1'b1; ld_a_const = ac; ld_a_val = 16'(av);
        ld_b_const = bc; ld_b_val = 16'(bv); ld_size = 2'(code);
        #2;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        put_load(1'b1, 0, 1'b0, 3, 1);
        chk("R9 reset empty", conflict, 1'b0);

        // R3 R4 R5 R6: offset sweep near zero, shared base register 3
        for (int so = -12; so <= 12; so++)
            for (int lo = -12; lo <= 12; lo++)
                for (int sc = 0; sc < 4; sc++)
                    for (int lc = 0; lc < 4; lc++) begin
                        ld_en = 1'b0;
                        put_store(1'b1, so, 1'b0, 3, sc);
                        put_load(1'b1, lo, 1'b0, 3, lc);
                        chk("R3/R4/R5/R6 offset sweep", conflict, exp_ovl(so, sc, lo, lc));
                    end

        // R11: extremes of the signed range
        for (int d = 0; d < 12; d++)
            for (int sc = 1; sc < 3; sc++) begin
                ld_en = 1'b0;
                put_store(1'b1, 32767 - d, 1'b0, 5, sc);
                put_load(1'b1, 32767, 1'b0, 5, 1);
                chk("R11 top end", conflict, exp_ovl(32767 - d, sc, 32767, 1));
                ld_en = 1'b0;
                put_store(1'b1, -32768 + d, 1'b0, 5, 1);
                put_load(1'b1, -32768, 1'b0, 5, sc);
                chk("R11 bottom end", conflict, exp_ovl(-32768 + d, 1, -32768, sc));
                put_load(1'b1, 32767, 1'b0, 5, 2);
                chk("R11 far apart", conflict, 1'b0);
            end

        // R1 R2: register pairs
        for (int r = 0; r < 8; r++)
            for (int q = 0; q < 8; q++) begin
                ld_en = 1'b0;
                put_store(1'b0, r, 1'b0, q, 1);
                put_load(1'b0, r, 1'b0, q, 2);
                chk("R1 same order", conflict, 1'b1);
                put_load(1'b0, q, 1'b0, r, 1);
                chk("R2 crossed", conflict, 1'b1);
                put_load(1'b0, r, 1'b0, q + 9, 1);
                chk("R1 mismatch", conflict, 1'b0);
                put_load(1'b1, r, 1'b0, q, 1);
                chk("R1 kind differs", conflict, (r == q) ? 1'b0 : 1'b0);
            end

        // R2 crossed with a constant operand
        ld_en = 1'b0;
        put_store(1'b1, 40, 1'b0, 7, 1);
        put_load(1'b0, 7, 1'b1, 40, 1);
        chk("R2 const crossed", conflict, 1'b1);

        // R10: ld_en low
        ld_en = 1'b0; #1;
        chk("R10 idle", conflict, 1'b0);

        // R7: overwrite
        put_store(1'b0, 9, 1'b0, 10, 1);
        put_load(1'b0, 1, 1'b0, 2, 1);
        chk("R7 old pair gone", conflict, 1'b0);
        put_load(1'b0, 9, 1'b0, 10, 1);
        chk("R7 new pair live", conflict, 1'b1);
        ld_en = 1'b0;
        put_store(1'b0, 9, 1'b0, 10, 0);
        put_load(1'b0, 9, 1'b0, 10, 1);
        chk("R7 R6 size replaced by zero", conflict, 1'b0);

        // R8: clear, with priority over a store
        ld_en = 1'b0;
        put_store(1'b0, 4, 1'b0, 6, 2);
        grp_end = 1'b1;
        put_store(1'b0, 4, 1'b0, 6, 2);
        grp_end = 1'b0;
        put_load(1'b0, 4, 1'b0, 6, 2);
        chk("R8 clear wins", conflict, 1'b0);

        // R9: reset mid-run
        ld_en = 1'b0;
        put_store(1'b0, 4, 1'b0, 6, 2);
        rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
        put_load(1'b0, 4, 1'b0, 6, 2);
        chk("R9 reset clears", conflict, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule